// File: doc/BRIEF.md
# High/Low-Time Programmable Clock Divider

This block divides a reference clock by an integer ratio whose two phases are programmed separately. A high count sets how many reference cycles the divided output stays high, and a low count sets how many it stays low, so the output period is their sum. An odd ratio is expressed by making the low count one larger than the high count. A bypass flag routes the reference clock straight to the output for a ratio of one.

A new setting is accepted only when a full low phase has finished. The output therefore never shows a shortened high or low pulse while software or a sequencer changes the ratio. A small combinational encoder on separate ports turns a requested ratio from 1 to 126 into the matching high, low, odd and bypass fields. The caller can feed those fields back into the divider inputs.

Top module: `clk_hilo_div`

## Requirements
- R1: With bypass off, the output stays high for exactly the high count and low for exactly the low count, counted in reference cycles, so one output period is their sum.
- R2: A high or low count of zero, with bypass off, behaves exactly like a count of one.
- R3: While the accepted setting has bypass set, the output equals the reference clock in both of its phases.
- R4: A setting change (high count, low count or bypass) presented during a high phase or before the last cycle of a low phase has no effect until the current low phase has run its full length.
- R5: The setting present during the last reference cycle of a low phase governs the very next high phase and the low phase after it.
- R6: A synchronous reset drives the output low and starts a low phase that lasts the low count present at reset; this also holds when reset arrives in the middle of a high phase.
- R7: The encoder gives a high count of the requested ratio halved and rounded down, and a low count of it halved and rounded up.
- R8: The encoder odd flag is 1 exactly when the requested ratio is odd, and its bypass flag is 1 exactly when the ratio is 1, so that bypass, or the sum of the two counts, returns the requested ratio.
- R9: When bypass is cleared, the output leaves bypass at the next reference edge with a high phase of the new high count, followed by the new low count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Reference clock; also the clock of all state |
| rst | input | 1 | Synchronous reset, active high |
| div_high | input | 6 | Requested high-phase length in reference cycles |
| div_low | input | 6 | Requested low-phase length in reference cycles |
| div_bypass | input | 1 | Requests that the reference clock be passed through |
| clk_out | output | 1 | Divided or bypassed clock |
| req_ratio | input | 7 | Ratio to encode, valid from 1 to 126 |
| enc_high | output | 6 | Encoded high count |
| enc_low | output | 6 | Encoded low count |
| enc_odd | output | 1 | Encoded odd-ratio flag |
| enc_bypass | output | 1 | Encoded bypass flag |

## Verification
The reload of a new setting and the end of a low phase can occur in the same reference cycle. The bench provokes this by changing the fields in the final low cycle, and by changing them one cycle into a high phase. It then judges the outcome by the lengths of the runs that follow: new lengths must appear at once in the first case, and only after a full old low phase in the second. Reset landing inside a high phase, and bypass being requested or withdrawn at a phase edge, are judged in the same way by run lengths and by sampling the output in both halves of the reference clock.

// File: rtl/clk_hilo_div.sv
module clk_hilo_div #(
  parameter int W = 6
) (
  input  logic         clk_in,
  input  logic         rst,
  input  logic [W-1:0] div_high,
  input  logic [W-1:0] div_low,
  input  logic         div_bypass,
  output logic         clk_out,
  input  logic [W:0]   req_ratio,
  output logic [W-1:0] enc_high,
  output logic [W-1:0] enc_low,
  output logic         enc_odd,
  output logic         enc_bypass
);
  localparam int RW = W + 1;
  localparam logic [W-1:0] ONE = W'(1);
  localparam int MAXR = 2 * ((1 << W) - 1);

  function automatic logic [W-1:0] fix(input logic [W-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  logic         out_q;
  logic         act_byp;
  logic [W-1:0] act_l;
  logic [W-1:0] cnt;
  logic         boundary;

  assign boundary = !out_q && (cnt == '0);

  always_ff @(posedge clk_in) begin
    if (rst) begin
      out_q   <= 1'b0;
      act_l   <= div_low;
      act_byp <= div_bypass;
      cnt     <= fix(div_low) - ONE;
    end else if (boundary) begin
      act_l   <= div_low;
      act_byp <= div_bypass;
      if (div_bypass) begin
        cnt   <= '0;
      end else begin
        out_q <= 1'b1;
        cnt   <= fix(div_high) - ONE;
      end
    end else if (cnt == '0) begin
      out_q <= 1'b0;
      cnt   <= fix(act_l) - ONE;
    end else begin
      cnt   <= cnt - ONE;
    end
  end

  assign clk_out = act_byp ? clk_in : out_q;

  assign enc_high   = req_ratio[RW-1:1];
  assign enc_low    = req_ratio[RW-1:1] + W'(req_ratio[0]);
  assign enc_odd    = req_ratio[0];
  assign enc_bypass = (req_ratio == RW'(1));

  always @(negedge clk_in) begin
    if (rst) AST_RESET_LOW: assert (!out_q); // R6
  end

  always_comb begin
    if (req_ratio >= RW'(1) && int'(req_ratio) <= MAXR) begin
      AST_ENC_RATIO: assert ((enc_bypass ? RW'(1) : RW'(enc_high) + RW'(enc_low)) == req_ratio); // R8
      AST_ENC_SPLIT: assert ((enc_low - enc_high) == W'(enc_odd)); // R7
    end
  end

  AST_RELOAD_AT_EDGE: assert property (@(posedge clk_in) disable iff (rst)
    (!$stable(act_l) || !$stable(act_byp)) |-> ($past(boundary) || $past(rst))); // R4
  AST_RISE_AT_EDGE: assert property (@(posedge clk_in) disable iff (rst)
    $rose(out_q) |-> $past(boundary && !div_bypass)); // R4
  AST_LOW_HOLDS: assert property (@(posedge clk_in) disable iff (rst)
    (!out_q && cnt != '0) |=> !out_q); // R1
  AST_LOW_BOUND: assert property (@(posedge clk_in) disable iff (rst)
    !out_q |-> (cnt < fix(act_l))); // R2
  AST_BYPASS_IDLE: assert property (@(posedge clk_in) disable iff (rst)
    act_byp |-> !out_q); // R3
endmodule

// File: tb/sim_clk_hilo_div.sv
module sim_clk_hilo_div;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] div_high = '0;
  logic [5:0] div_low = '0;
  logic       div_bypass = 1'b0;
  logic [6:0] req_ratio = '0;
  logic       clk_out;
  logic [5:0] enc_high, enc_low;
  logic       enc_odd, enc_bypass;

  int errors = 0;
  int checks = 0;
  int runlen = 0;

  always #10 clk = ~clk;

  clk_hilo_div #(.W(6)) u0 (
    .clk_in(clk), .rst(rst), .div_high(div_high), .div_low(div_low),
    .div_bypass(div_bypass), .clk_out(clk_out), .req_ratio(req_ratio),
    .enc_high(enc_high), .enc_low(enc_low), .enc_odd(enc_odd),
    .enc_bypass(enc_bypass));

  // {high, low, expected high run, expected low run}
  localparam logic [23:0] VEC [10] = '{
    {6'd1,  6'd1,  6'd1,  6'd1},
    {6'd1,  6'd2,  6'd1,  6'd2},
    {6'd2,  6'd1,  6'd2,  6'd1},
    {6'd4,  6'd4,  6'd4,  6'd4},
    {6'd5,  6'd6,  6'd5,  6'd6},
    {6'd9,  6'd3,  6'd9,  6'd3},
    {6'd0,  6'd4,  6'd1,  6'd4},
    {6'd7,  6'd0,  6'd7,  6'd1},
    {6'd0,  6'd0,  6'd1,  6'd1},
    {6'd63, 6'd63, 6'd63, 6'd63}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic next_sample();
    @(negedge clk);
    #1;
  endtask

  task automatic count_run(input logic v);
    runlen = 0;
    while (clk_out === v && runlen < 300) begin
      runlen++;
      next_sample();
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    next_sample();
    rst = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    next_sample();
    next_sample();
    check(clk_out === 1'b0, "R6 reset state", int'(clk_out), 0);

    for (int i = 0; i < 10; i++) begin
      string tag;
      div_high   = VEC[i][23:18];
      div_low    = VEC[i][17:12];
      div_bypass = 1'b0;
      tag = (VEC[i][23:18] == 0 || VEC[i][17:12] == 0) ? "R2" : "R1";
      do_reset();
      count_run(1'b0);
      check(runlen == int'(VEC[i][5:0]), "R6 first low run", runlen, int'(VEC[i][5:0]));
      count_run(1'b1);
      check(runlen == int'(VEC[i][11:6]), {tag, " high run"}, runlen, int'(VEC[i][11:6]));
      count_run(1'b0);
      check(runlen == int'(VEC[i][5:0]), {tag, " low run"}, runlen, int'(VEC[i][5:0]));
    end

    // R4: change during high phase waits for a full old low phase
    div_high = 6'd3; div_low = 6'd5;
    do_reset();
    count_run(1'b0);
    div_high = 6'd2; div_low = 6'd2;
    count_run(1'b1);
    check(runlen == 3, "R4 old high kept", runlen, 3);
    count_run(1'b0);
    check(runlen == 5, "R4 old low kept", runlen, 5);
    count_run(1'b1);
    check(runlen == 2, "R4 new high", runlen, 2);
    count_run(1'b0);
    check(runlen == 2, "R4 new low", runlen, 2);

    // R5: change in last low cycle takes effect at once
    div_high = 6'd2; div_low = 6'd3;
    do_reset();
    next_sample();
    next_sample();
    div_high = 6'd4; div_low = 6'd1;
    next_sample();
    count_run(1'b1);
    check(runlen == 4, "R5 high from last-cycle setting", runlen, 4);
    count_run(1'b0);
    check(runlen == 1, "R5 low from last-cycle setting", runlen, 1);

    // R6: reset inside a high phase
    div_high = 6'd6; div_low = 6'd6;
    do_reset();
    count_run(1'b0);
    next_sample();
    do_reset();
    check(clk_out === 1'b0, "R6 low after mid-high reset", int'(clk_out), 0);
    count_run(1'b0);
    check(runlen == 6, "R6 low run after mid-high reset", runlen, 6);

    // R4/R3: bypass requested during high phase
    div_high = 6'd3; div_low = 6'd3;
    do_reset();
    count_run(1'b0);
    div_bypass = 1'b1;
    count_run(1'b1);
    check(runlen == 3, "R4 high not cut by bypass", runlen, 3);
    for (int k = 1; k <= 3; k++) begin
      check(clk_out === 1'b0, "R4 low kept before bypass", int'(clk_out), 0);
      @(posedge clk);
      #5;
      check(clk_out === (k == 3), "R4 bypass only after low", int'(clk_out), int'(k == 3));
      next_sample();
    end
    for (int k = 0; k < 4; k++) begin
      @(posedge clk);
      #5;
      check(clk_out === 1'b1, "R3 bypass high half", int'(clk_out), 1);
      @(negedge clk);
      #5;
      check(clk_out === 1'b0, "R3 bypass low half", int'(clk_out), 0);
    end

    // R9: leaving bypass
    next_sample();
    div_bypass = 1'b0; div_high = 6'd3; div_low = 6'd2;
    next_sample();
    count_run(1'b1);
    check(runlen == 3, "R9 high after bypass", runlen, 3);
    count_run(1'b0);
    check(runlen == 2, "R9 low after bypass", runlen, 2);

    // R3: reset with bypass requested
    div_bypass = 1'b1;
    do_reset();
    @(posedge clk);
    #5;
    check(clk_out === 1'b1, "R3 bypass from reset high", int'(clk_out), 1);
    @(negedge clk);
    #5;
    check(clk_out === 1'b0, "R3 bypass from reset low", int'(clk_out), 0);
    div_bypass = 1'b0;

    // R7/R8: encoder round trip
    for (int n = 1; n <= 126; n++) begin
      int dec;
      req_ratio = 7'(n);
      #1;
      check(int'(enc_high) == n / 2 && int'(enc_low) == (n + 1) / 2,
            "R7 encoder split", int'(enc_high) * 100 + int'(enc_low), (n / 2) * 100 + (n + 1) / 2);
      dec = enc_bypass ? 1 : int'(enc_high) + int'(enc_low);
      check(dec == n && enc_odd == n[0] && enc_bypass == (n == 1),
            "R8 encoder flags and ratio", dec, n);
    end

    summary();
    $finish;
  end
endmodule